// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause 22 MDIO master that sits behind a small word-addressed register port. Software programs a divisor and an enable bit, optionally loads a 16-bit value to send, then writes one control word that names the PHY, the PHY register and the direction and sets a start bit. The block then clocks out a complete management frame on MDC and MDIO. For a read, it releases MDIO for the turnaround and data phase and collects the PHY's answer.

A ready flag in the control register tells software when the block is idle. The 16 bits read from the PHY are then available in the read-data register. MDC idles low. The clock runs only while a frame is in flight and the enable bit is set. Clearing the enable bit in the middle of a frame freezes the frame where it stands, and setting the bit again lets the frame continue.

Register words are selected by a 2-bit index:

| Index | Register |
|---|---|
| 0 | configuration |
| 1 | control |
| 2 | write data |
| 3 | read data |

Top module: `mdio_master`

## Requirements
- R1: After reset, word 0 reads 0 and word 1 reads 0x0000_0080 (ready set). MDC is low, `mdio_oe` is low and word 3 reads 0.
- R2: The fields of control word 1 read back as written while idle: PHY address in bits 28:24, register address in bits 20:16, read request in bit 15, write request in bit 14. The start bit 11 always reads 0, and bit 7 is the ready flag.
- R3: Writing word 1 with bit 11 set and exactly one of bits 15/14 set starts a frame. Bit 7 reads 0 from the next cycle. It reads 1 again exactly 128×(divisor+1) cycles after the accepting edge.
- R4: The frame is sent MSB first, in this order: 32 ones; the start pattern 01; the opcode (10 for a read, 01 for a write); the 5-bit PHY address; the 5-bit register address; a two-bit turnaround (10 on a write); then 16 data bits. MDIO changes only on a falling MDC edge or at the start of the frame.
- R5: Word 0 holds the divisor in bits 5:0 and the enable in bit 6. One MDC half period lasts divisor+1 system clocks, and the first rising MDC edge comes divisor+1 cycles after the frame starts.
- R6: On a read, `mdio_oe` is low for the final 18 bit periods (turnaround and data). `mdio_in` is sampled on each rising MDC edge of the data phase. The 16 captured bits appear in word 3 once ready returns.
- R7: Write data is taken from word 2 when the frame starts. Writing word 2 while the frame is in progress does not change the bits sent.
- R8: A write to word 1 while a frame is in progress is ignored. The frame continues unchanged, and the stored control fields keep their values.
- R9: A start request whose bits 15 and 14 are both 0 or both 1 starts nothing. Ready stays 1 and MDC stays low.
- R10: While the enable bit is 0, MDC does not toggle. A frame started in that state holds ready at 0 until the enable bit is set, and then completes normally.
- R11: Whenever the block is idle, MDC is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable (high = master drives) |
| mdio_in | input | 1 | MDIO value seen on the wire |

## Verification
The hardest states to reach from the ports are the ones where something happens in the middle of a frame. These are a rewrite of the write-data word, a second start request, and a frame stalled because the enable bit was cleared before it began. The stimulus reaches them by issuing register writes from inside the loop that polls the ready flag, at fixed cycle offsets after the start. For the stall case, the bench starts a frame with the enable clear and watches MDC and ready for a while before setting the enable. A PHY model counts falling MDC edges to know which bit of the frame is current, and drives read data from that count. Each frame is captured bit by bit on rising MDC and compared against a vector built from the request.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        WORD_CFG   = 2'd0,
        WORD_CTRL  = 2'd1,
        WORD_WDATA = 2'd2,
        WORD_RDATA = 2'd3
    } word_sel_e;

    localparam int CTRL_PHY_LSB = 24;
    localparam int CTRL_REG_LSB = 16;
    localparam int CTRL_RD_BIT  = 15;
    localparam int CTRL_WR_BIT  = 14;
    localparam int CTRL_GO_BIT  = 11;
    localparam int CTRL_RDY_BIT = 7;
    localparam int ADDR_W       = 5;
    localparam int DATA_W       = 16;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } clk_st_t;

    clk_st_t s_d, s_q;
    logic    tick;

    assign tick = run && (s_q.cnt >= div);
    assign rise = tick && !s_q.mdc;
    assign fall = tick && s_q.mdc;
    assign mdc  = s_q.mdc;

    always_comb begin
        s_d = s_q;
        if (run) begin
            if (tick) begin
                s_d.cnt = '0;
                s_d.mdc = !s_q.mdc;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(s_q.mdc)); // R10
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_in,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam int FRAME_LEN  = PRE_LEN + 4 + 2*ADDR_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int TA_START   = PRE_LEN + 4 + 2*ADDR_W;
    localparam int DATA_START = TA_START + 2;

    typedef struct packed {
        logic                 busy;
        logic                 is_rd;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] shreg;
        logic [DATA_W-1:0]    rsh;
        logic [DATA_W-1:0]    rdata;
    } eng_st_t;

    eng_st_t s_d, s_q;
    logic [1:0]        op_bits;
    logic [1:0]        ta_bits;
    logic [DATA_W-1:0] data_bits;

    assign op_bits   = start_rd ? 2'b10 : 2'b01;
    assign ta_bits   = start_rd ? 2'b00 : 2'b10;
    assign data_bits = start_rd ? '0 : wdata;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.busy  = 1'b1;
            s_d.is_rd = start_rd;
            s_d.idx   = '0;
            s_d.shreg = {{PRE_LEN{1'b1}}, 2'b01, op_bits, phy, regad, ta_bits, data_bits};
        end else if (s_q.busy) begin
            if (rise && s_q.is_rd && (s_q.idx >= IDX_W'(DATA_START)))
                s_d.rsh = {s_q.rsh[DATA_W-2:0], mdio_in};
            if (fall) begin
                if (s_q.idx == IDX_W'(FRAME_LEN - 1)) begin
                    s_d.busy = 1'b0;
                    if (s_q.is_rd) s_d.rdata = s_q.rsh;
                end else begin
                    s_d.idx   = s_q.idx + 1'b1;
                    s_d.shreg = {s_q.shreg[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign rdata    = s_q.rdata;
    assign mdio_out = s_q.shreg[FRAME_LEN-1];
    assign mdio_oe  = s_q.busy && !(s_q.is_rd && (s_q.idx >= IDX_W'(TA_START)));

    AST_FRAME_OPENS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> (mdio_oe && mdio_out)); // R4
    AST_BITS_MOVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !fall && !start) |=> $stable(mdio_out)); // R4
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 6,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    localparam int EN_BIT = DIV_W;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              en;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  busy, rise, fall, start, ctrl_wr, op_onehot;
    logic [DATA_W-1:0] rdata;
    logic  unused_bits;

    assign unused_bits = ^{reg_wdata[31:29], reg_wdata[23:21], reg_wdata[13:12],
                           reg_wdata[10:0]};

    assign ctrl_wr   = reg_wr && (word_sel_e'(reg_addr) == WORD_CTRL);
    assign op_onehot = reg_wdata[CTRL_RD_BIT] ^ reg_wdata[CTRL_WR_BIT];
    assign start     = ctrl_wr && !busy && reg_wdata[CTRL_GO_BIT] && op_onehot;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            unique case (word_sel_e'(reg_addr))
                WORD_CFG: begin
                    r_d.div = reg_wdata[DIV_W-1:0];
                    r_d.en  = reg_wdata[EN_BIT];
                end
                WORD_CTRL: begin
                    if (!busy) begin
                        r_d.phy   = reg_wdata[CTRL_PHY_LSB +: ADDR_W];
                        r_d.regad = reg_wdata[CTRL_REG_LSB +: ADDR_W];
                        r_d.rd    = reg_wdata[CTRL_RD_BIT];
                        r_d.wr    = reg_wdata[CTRL_WR_BIT];
                    end
                end
                WORD_WDATA: r_d.wdata = reg_wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (word_sel_e'(reg_addr))
            WORD_CFG: begin
                reg_rdata[DIV_W-1:0] = r_q.div;
                reg_rdata[EN_BIT]    = r_q.en;
            end
            WORD_CTRL: begin
                reg_rdata[CTRL_PHY_LSB +: ADDR_W] = r_q.phy;
                reg_rdata[CTRL_REG_LSB +: ADDR_W] = r_q.regad;
                reg_rdata[CTRL_RD_BIT]            = r_q.rd;
                reg_rdata[CTRL_WR_BIT]            = r_q.wr;
                reg_rdata[CTRL_RDY_BIT]           = !busy;
            end
            WORD_WDATA: reg_rdata[DATA_W-1:0] = r_q.wdata;
            default:    reg_rdata[DATA_W-1:0] = rdata;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy && r_q.en),
        .div  (r_q.div),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .start_rd(reg_wdata[CTRL_RD_BIT]),
        .phy     (reg_wdata[CTRL_PHY_LSB +: ADDR_W]),
        .regad   (reg_wdata[CTRL_REG_LSB +: ADDR_W]),
        .wdata   (r_q.wdata),
        .rise    (rise),
        .fall    (fall),
        .mdio_in (mdio_in),
        .busy    (busy),
        .rdata   (rdata),
        .mdio_out(mdio_out),
        .mdio_oe (mdio_oe)
    );

    AST_START_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R3
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr) |=> ($stable(r_q.phy) && $stable(r_q.regad) && busy)); // R8
    AST_BAD_OPCODE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctrl_wr && !op_onehot) |=> !busy); // R9
    AST_DISABLED_MDC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.en |=> $stable(mdc)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R11
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe, mdio_in;

    int checks = 0;
    int fails  = 0;

    int          cap_n = 0;
    int          fall_n = 0;
    int          cap_base = 0;
    int          fall_base = 0;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;
    logic [15:0] phy_val = '0;

    always #10 clk = ~clk;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always @(posedge mdc) begin
        cap_o  = {cap_o[62:0], mdio_out};
        cap_oe = {cap_oe[62:0], mdio_oe};
        cap_n  = cap_n + 1;
    end

    always @(negedge mdc) fall_n = fall_n + 1;

    function automatic logic phy_bit(input int k, input logic [15:0] v);
        if (k >= 48 && k <= 63) return v[63-k];
        if (k == 47) return 1'b0;
        return 1'b1;
    endfunction

    assign mdio_in = phy_bit(fall_n - fall_base, phy_val);

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 2'd1;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [4:0] p, input logic [4:0] g,
                                              input logic rd, input logic wr, input logic go);
        return {3'b0, p, 3'b0, g, rd, wr, 2'b0, go, 11'b0};
    endfunction

    // poll ready; optional mid-frame pokes; returns busy cycles and first MDC high cycle
    task automatic poll(input bit poke, input logic [15:0] wd, input logic [4:0] p,
                        output int busy_cyc, output int first_hi);
        busy_cyc = 0; first_hi = -1;
        forever begin
            #1;
            if (reg_rdata[7]) break;
            if (mdc && first_hi < 0) first_hi = busy_cyc;
            if (poke && (busy_cyc == 10 || busy_cyc == 20)) begin
                reg_wr = 1'b1;
                if (busy_cyc == 10) begin reg_addr = 2'd2; reg_wdata = {16'h0, ~wd}; end
                else begin reg_addr = 2'd1; reg_wdata = ctrl_word(~p, 5'h0, 1'b0, 1'b1, 1'b1); end
                @(negedge clk);
                reg_wr = 1'b0; reg_addr = 2'd1;
                busy_cyc++;
                continue;
            end
            busy_cyc++;
            if (busy_cyc > 20000) break;
            @(negedge clk);
        end
    endtask

    task automatic run_txn(input int div, input bit rd, input logic [4:0] p,
                           input logic [4:0] g, input logic [15:0] wd,
                           input bit poke, input bit stall);
        int busy_cyc, first_hi, bad;
        logic [63:0] exp_o, exp_oe;
        logic [31:0] v;
        wr_reg(2'd0, {25'b0, !stall, 6'(div)});
        wr_reg(2'd2, {16'h0, wd});
        phy_val  = {p, g, 6'h15} ^ 16'(div);
        cap_base = cap_n; fall_base = fall_n;
        wr_reg(2'd1, ctrl_word(p, g, rd, !rd, 1'b1));
        if (stall) begin
            bad = 0;
            for (int i = 0; i < 40; i++) begin
                #1 if (mdc || reg_rdata[7]) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R10 stalled frame keeps MDC low and ready 0", 64'(bad), 64'd0);
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = {25'b0, 1'b1, 6'(div)};
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = 2'd1;
        end
        poll(poke, wd, p, busy_cyc, first_hi);
        if (!stall)
            check(busy_cyc == 128*(div+1), "R3 busy duration", 64'(busy_cyc), 64'(128*(div+1)));
        check(first_hi == div+1, "R5 first MDC rise", 64'(first_hi), 64'(div+1));
        check(cap_n - cap_base == 64, "R4 bit count", 64'(cap_n - cap_base), 64'd64);
        exp_o  = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, g, 2'b10, rd ? 16'h0 : wd};
        exp_oe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        check((cap_o & exp_oe) == (exp_o & exp_oe),
              poke ? "R7 R4 frame bits" : "R4 frame bits", cap_o & exp_oe, exp_o & exp_oe);
        check(cap_oe == exp_oe, rd ? "R6 mdio_oe release" : "R4 mdio_oe driven", cap_oe, exp_oe);
        rd_reg(2'd1, v);
        check(v == (ctrl_word(p, g, rd, !rd, 1'b0) | 32'h80),
              poke ? "R8 R2 control readback" : "R2 control readback",
              64'(v), 64'(ctrl_word(p, g, rd, !rd, 1'b0) | 32'h80));
        if (rd) begin
            rd_reg(2'd3, v);
            check(v == {16'h0, phy_val}, "R6 read data", 64'(v), 64'(phy_val));
        end
        #1 check(!mdc && !mdio_oe, "R11 idle lines", {62'h0, mdc, mdio_oe}, 64'd0);
    endtask

    initial begin
        logic [31:0] v;
        int bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        rd_reg(2'd0, v); check(v == 32'h0, "R1 config reset", 64'(v), 64'h0);
        rd_reg(2'd1, v); check(v == 32'h80, "R1 control reset", 64'(v), 64'h80);
        rd_reg(2'd3, v); check(v == 32'h0, "R1 read data reset", 64'(v), 64'h0);
        check(!mdc && !mdio_oe, "R1 lines at reset", {62'h0, mdc, mdio_oe}, 64'd0);

        for (int a = 0; a < 32; a++)
            run_txn(0, a[0], 5'(a), 5'(31 - a), 16'(a * 16'h0913 + 16'h5A3C), 1'b0, 1'b0);
        for (int d = 0; d < 4; d++) begin
            run_txn(d, 1'b1, 5'(d + 9), 5'(d * 7), 16'h0, 1'b0, 1'b0);
            run_txn(d, 1'b0, 5'(d + 17), 5'(d * 5), 16'hC3A5 ^ 16'(d), 1'b0, 1'b0);
        end
        run_txn(29, 1'b0, 5'h01, 5'h00, 16'h8001, 1'b0, 1'b0);
        run_txn(2, 1'b0, 5'h0A, 5'h15, 16'hBEEF, 1'b1, 1'b0);
        run_txn(1, 1'b1, 5'h12, 5'h0C, 16'h0, 1'b1, 1'b0);
        run_txn(1, 1'b1, 5'h03, 5'h07, 16'h0, 1'b0, 1'b1);

        wr_reg(2'd0, {25'b0, 1'b1, 6'd0});
        for (int op = 0; op < 4; op += 3) begin
            wr_reg(2'd1, ctrl_word(5'h05, 5'h06, op[1], op[0], 1'b1));
            bad = 0;
            for (int i = 0; i < 30; i++) begin
                #1 if (!reg_rdata[7] || mdc) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R9 non-one-hot opcode starts nothing", 64'(bad), 64'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule